// File: doc/BRIEF.md
# SDRAM Burst Read Column Sequencer

This block turns a read request aimed at a row that is already open into a single column read command on the SDRAM command pins, then follows the burst beat by beat. For every beat it works out which column the memory is returning, so each captured 16-bit word leaves the block paired with its column address. The burst length, the ordering of the columns and the read latency are sampled from configuration inputs at the moment a request is taken. Later changes to those inputs only affect the next burst.

A burst is one to eight words, or an endless full-page burst that wraps around all 512 columns of the row. It can be cut short with a stop request. The stop makes the block drive a burst-terminate command, and no words are delivered for beats that would have started on or after that command. Address bit 10 of the read command carries the request's auto-precharge flag. Opening rows, writes, refresh and arbitration between requesters are left to neighbouring logic.

Top module: `sdram_burst_read_seq`

## Requirements
- R1: When a request is accepted (`req_valid` high while `req_ready` is high), the next cycle drives a read command: `sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=0, `sd_we_n`=1, `sd_ba` = bank, `sd_addr[8:0]` = start column, `sd_addr[10]` = auto-precharge flag, and all other address bits 0. Any cycle that carries neither a read nor a terminate command is a no-op (0,1,1,1) with bank and address 0.
- R2: `req_ready` is low from the read command cycle until the cycle after the last beat is issued. A request made while `req_ready` is low is ignored and produces no command.
- R3: `cfg_blen` encodes the burst length as 0→1, 1→2, 2→4, 3→8 and 7→full page. Codes 4 to 6 behave as length 1. A burst issues one beat per cycle, starting in the read command cycle.
- R4: In sequential order (`cfg_interleave`=0), beat k has the start column with its low log2(BL) bits replaced by (start + k) mod BL, so the burst wraps inside its aligned block.
- R5: In interleaved order (`cfg_interleave`=1) with a finite length, beat k has column start XOR k.
- R6: A full-page burst uses column (start + k) mod 512, ignores `cfg_interleave`, and runs until a stop request.
- R7: `stop_req` during a burst causes a terminate command (0,1,1,0) in the next cycle and ends the burst. Beats issued before that cycle are still delivered, and none after. `stop_req` while idle has no effect.
- R8: `cfg_cas3` selects a latency CL of 2 (value 0) or 3 (value 1). A beat issued in cycle t gives `rd_valid` high in cycle t+CL+1, with `rd_data` equal to `sd_dq_in` during cycle t+CL and `rd_col` equal to that beat's column.
- R9: After reset, `req_ready` is 1, `rd_valid` is 0 and the command pins show a no-op. `rd_valid` stays low in every cycle where no beat is due.
- R10: The length, order and latency are captured when a request is accepted. Changing them during a burst does not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | High when a request can be taken |
| req_bank | input | 2 | Bank of the request |
| req_col | input | 9 | Start column |
| req_ap | input | 1 | Auto-precharge after the burst |
| cfg_blen | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 = interleaved order |
| cfg_cas3 | input | 1 | 1 = latency 3, 0 = latency 2 |
| stop_req | input | 1 | Terminate the running burst |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address pins |
| sd_addr | output | 13 | Address pins |
| sd_dq_in | input | 16 | Data returned by the memory |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | 16 | Captured word |
| rd_col | output | 9 | Column of the captured word |

## Verification
The assertions check these on every cycle: a read command carries the bank, column and precharge flag of the accepted request; only no-ops fill the rest of a burst; a terminate command only ever follows a stop request during a burst; a full-page burst never ends by itself; the beat counter stays inside the programmed length; and no word is delivered without a beat issued before it. The bench's scenarios are needed to show the exact column orders for each ordering and length, including the wrap at the aligned block and at column 511. They also show the cycle in which each word lands for both latencies, which beats survive a stop placed at different points, and that configuration changes in the middle of a burst have no effect on it.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  // command pin order: cs_n, ras_n, cas_n, we_n
  typedef enum logic [3:0] {
    SDR_READ = 4'b0101,
    SDR_BST  = 4'b0110,
    SDR_NOP  = 4'b0111
  } sdr_cmd_e;

  localparam logic [2:0] BLEN_FULL = 3'd7;
endpackage

// File: rtl/sdram_rd_colgen.sv
module sdram_rd_colgen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             interleave,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] xor_col;

  always_comb begin
    seq_col = (start_col & ~wrap_mask) | ((start_col + beat) & wrap_mask);
    xor_col = start_col ^ beat;
    col     = interleave ? xor_col : seq_col;
  end
endmodule

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  input  logic [2:0]        cfg_blen,
  input  logic              cfg_interleave,
  input  logic              cfg_cl_long,
  input  logic              stop_req,
  output logic              ready,
  output sdr_cmd_e          cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              issue,
  output logic [COL_W-1:0]  beat_col,
  output logic              cl_long
);
  logic              busy_q, busy_d;
  logic [COL_W-1:0]  beat_q, beat_d;
  logic [COL_W-1:0]  start_q;
  logic [COL_W-1:0]  mask_q, mask_dec;
  logic              il_q, full_q, cl_q;
  sdr_cmd_e          cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              accept, halt, last_beat;

  always_comb begin
    case (cfg_blen)
      3'd1:      mask_dec = COL_W'(1);
      3'd2:      mask_dec = COL_W'(3);
      3'd3:      mask_dec = COL_W'(7);
      BLEN_FULL: mask_dec = '1;
      default:   mask_dec = '0;
    endcase
  end

  always_comb begin
    accept    = req_valid && !busy_q;
    halt      = stop_req && busy_q;
    last_beat = busy_q && !full_q && (beat_q == mask_q);

    busy_d = busy_q;
    beat_d = beat_q;
    if (accept) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (halt || last_beat) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      beat_d = beat_q + COL_W'(1);
    end

    cmd_d  = SDR_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (accept) begin
      cmd_d                 = SDR_READ;
      ba_d                  = req_bank;
      addr_d[COL_W-1:0]     = req_col;
      addr_d[AP_BIT]        = req_ap;
    end else if (halt) begin
      cmd_d = SDR_BST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      start_q <= '0;
      mask_q  <= '0;
      il_q    <= 1'b0;
      full_q  <= 1'b0;
      cl_q    <= 1'b0;
      cmd_q   <= SDR_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      if (accept) begin
        start_q <= req_col;
        mask_q  <= mask_dec;
        il_q    <= cfg_interleave;
        full_q  <= (cfg_blen == BLEN_FULL);
        cl_q    <= cfg_cl_long;
      end
    end
  end

  sdram_rd_colgen #(.COL_W(COL_W)) u_colgen (
    .start_col (start_q),
    .beat      (beat_q),
    .wrap_mask (mask_q),
    .interleave(il_q & ~full_q),
    .col       (beat_col)
  );

  assign ready   = !busy_q;
  assign issue   = busy_q;
  assign cmd     = cmd_q;
  assign ba      = ba_q;
  assign addr    = addr_q;
  assign cl_long = cl_q;

  AST_BEAT_IN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !full_q |-> beat_q <= mask_q); // R3
  AST_FULLPAGE_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && full_q && !stop_req |=> busy_q); // R6
  AST_BST_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == SDR_BST |-> $past(stop_req && busy_q)); // R7
  AST_NOP_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) |-> cmd_q == SDR_NOP); // R2
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int DATA_W = 16,
  parameter int COL_W  = 9,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [COL_W-1:0]  beat_col,
  input  logic              cl_long,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col
);
  logic [MAX_CL-1:0] v_sr, v_sr_d;
  logic [COL_W-1:0]  c_sr   [MAX_CL];
  logic [COL_W-1:0]  c_sr_d [MAX_CL];
  logic              tap_v;
  logic [COL_W-1:0]  tap_c;
  logic              val_q;
  logic [DATA_W-1:0] dat_q;
  logic [COL_W-1:0]  col_q;

  always_comb begin
    v_sr_d = {v_sr[MAX_CL-2:0], issue};
    c_sr_d = c_sr;
    if (issue) c_sr_d[0] = beat_col;
    for (int i = 1; i < MAX_CL; i++) begin
      if (v_sr[i-1]) c_sr_d[i] = c_sr[i-1];
    end
  end

  generate
    if (MIN_CL == MAX_CL) begin : g_fixed_tap
      assign tap_v = v_sr[MAX_CL-1];
      assign tap_c = c_sr[MAX_CL-1];
    end else begin : g_sel_tap
      assign tap_v = cl_long ? v_sr[MAX_CL-1] : v_sr[MIN_CL-1];
      assign tap_c = cl_long ? c_sr[MAX_CL-1] : c_sr[MIN_CL-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_sr  <= '0;
      for (int i = 0; i < MAX_CL; i++) c_sr[i] <= '0;
      val_q <= 1'b0;
      dat_q <= '0;
      col_q <= '0;
    end else begin
      v_sr  <= v_sr_d;
      c_sr  <= c_sr_d;
      val_q <= tap_v;
      if (tap_v) begin
        dat_q <= dq_in;
        col_q <= tap_c;
      end
    end
  end

  assign rd_valid = val_q;
  assign rd_data  = dat_q;
  assign rd_col   = col_q;
endmodule

// File: rtl/sdram_burst_read_seq.sv
module sdram_burst_read_seq
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int AP_BIT = 10,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ap,
  input  logic [2:0]        cfg_blen,
  input  logic              cfg_interleave,
  input  logic              cfg_cas3,
  input  logic              stop_req,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  input  logic [DATA_W-1:0] sd_dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col
);
  localparam int OUTST_W = $clog2(MAX_CL + 3) + 1;

  sdr_cmd_e         cmd;
  logic             issue;
  logic [COL_W-1:0] beat_col;
  logic             cl_long;

  sdram_rd_ctrl #(
    .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_bank      (req_bank),
    .req_col       (req_col),
    .req_ap        (req_ap),
    .cfg_blen      (cfg_blen),
    .cfg_interleave(cfg_interleave),
    .cfg_cl_long   (cfg_cas3),
    .stop_req      (stop_req),
    .ready         (req_ready),
    .cmd           (cmd),
    .ba            (sd_ba),
    .addr          (sd_addr),
    .issue         (issue),
    .beat_col      (beat_col),
    .cl_long       (cl_long)
  );

  sdram_rd_capture #(
    .DATA_W(DATA_W), .COL_W(COL_W), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .beat_col(beat_col),
    .cl_long (cl_long),
    .dq_in   (sd_dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_col  (rd_col)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // beats issued but not yet delivered, for the checks below
  logic [OUTST_W-1:0] outst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst_q <= '0;
    else        outst_q <= outst_q + OUTST_W'(issue) - OUTST_W'(rd_valid);
  end

  AST_READ_CARRIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> cmd == SDR_READ && sd_ba == $past(req_bank) &&
    sd_addr[COL_W-1:0] == $past(req_col) && sd_addr[AP_BIT] == $past(req_ap)); // R1
  AST_NO_ORPHAN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> outst_q != '0); // R8
endmodule

// File: tb/sdram_burst_read_seq_tb.sv
module sdram_burst_read_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_ap;
  logic [1:0]  req_bank;
  logic [8:0]  req_col;
  logic [2:0]  cfg_blen;
  logic        cfg_interleave, cfg_cas3, stop_req;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_addr;
  logic [15:0] sd_dq_in;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [8:0]  rd_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_read_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_ap(req_ap),
    .cfg_blen(cfg_blen), .cfg_interleave(cfg_interleave), .cfg_cas3(cfg_cas3),
    .stop_req(stop_req), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state
  bit    m_active = 0;
  int    m_k, m_start, m_bl, m_cl;
  bit    m_full, m_il;
  string m_tag = "R4";
  int    exp_cmd = 4'b0111;
  int    exp_ba = 0;
  int    exp_addr = 0;
  bit    exp_v   [SLOTS];
  int    exp_col [SLOTS];
  int    exp_dat [SLOTS];
  string exp_tag [SLOTS];

  function automatic logic [15:0] pat(int c);
    return 16'((c * 40503 + 4660) ^ (c >> 3));
  endfunction

  function automatic int colf(int s, int k, int bl, bit full, bit il);
    int base;
    if (full) return (s + k) % 512;
    if (il) return s ^ k;
    base = s - (s % bl);
    return base + ((s % bl) + k) % bl;
  endfunction

  function automatic int blen_words(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic tick();
    int idx, j, cmdv;
    bit was_active;
    string ctag;
    idx = cyc % SLOTS;
    chk(rd_valid == exp_v[idx], "R8", "rd_valid", int'(rd_valid), int'(exp_v[idx]));
    if (exp_v[idx]) begin
      chk(int'(rd_col) == exp_col[idx], exp_tag[idx], "rd_col", int'(rd_col), exp_col[idx]);
      chk(int'(rd_data) == exp_dat[idx], "R8", "rd_data", int'(rd_data), exp_dat[idx]);
    end
    exp_v[idx] = 1'b0;
    cmdv = int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
    ctag = (exp_cmd == 4'b0110) ? "R7" : "R1";
    chk(cmdv == exp_cmd, ctag, "command", cmdv, exp_cmd);
    chk(int'(sd_ba) == exp_ba && int'(sd_addr) == exp_addr, ctag, "bank/addr",
        int'({sd_ba, sd_addr}), (exp_ba << 13) | exp_addr);
    chk(req_ready == !m_active, "R2", "req_ready", int'(req_ready), int'(!m_active));

    was_active = m_active;
    if (m_active) begin
      j = (cyc + m_cl + 1) % SLOTS;
      exp_v[j]   = 1'b1;
      exp_col[j] = colf(m_start, m_k, m_bl, m_full, m_il);
      exp_dat[j] = int'(pat(cyc + m_cl));
      exp_tag[j] = m_tag;
      m_k++;
    end
    exp_cmd = 4'b0111; exp_ba = 0; exp_addr = 0;
    if (!was_active && req_valid) begin
      m_active = 1; m_k = 0; m_start = int'(req_col);
      m_full = (cfg_blen == 3'd7); m_bl = blen_words(int'(cfg_blen));
      m_il = cfg_interleave; m_cl = cfg_cas3 ? 3 : 2;
      exp_cmd = 4'b0101; exp_ba = int'(req_bank);
      exp_addr = int'(req_col) | (int'(req_ap) << 10);
    end else if (was_active && stop_req) begin
      m_active = 0; exp_cmd = 4'b0110;
    end else if (was_active && !m_full && m_k == m_bl) begin
      m_active = 0;
    end
    @(negedge clk);
    cyc++;
    sd_dq_in = pat(cyc);
  endtask

  task automatic burst(string tag, int bank, int col, bit ap, int blen, bit il, bit cas3,
                       int stop_after, bit poke_busy, bit wiggle);
    while (m_active) tick();
    m_tag = tag;
    cfg_blen = 3'(blen); cfg_interleave = il; cfg_cas3 = cas3;
    req_bank = 2'(bank); req_col = 9'(col); req_ap = ap; req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    if (wiggle) begin // R10: configuration changed while the burst runs
      cfg_blen = 3'd7; cfg_interleave = ~il; cfg_cas3 = ~cas3;
    end
    if (poke_busy) begin // R2: request during burst must be ignored
      req_valid = 1'b1; req_col = 9'h0AA; tick(); req_valid = 1'b0;
    end
    if (stop_after >= 0) begin
      repeat (stop_after) tick();
      stop_req = 1'b1; tick(); stop_req = 1'b0;
    end
    while (m_active) tick();
    repeat (6) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin
      exp_v[i] = 1'b0; exp_col[i] = 0; exp_dat[i] = 0; exp_tag[i] = "R4";
    end
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0; req_ap = 1'b0;
    cfg_blen = '0; cfg_interleave = 1'b0; cfg_cas3 = 1'b0; stop_req = 1'b0;
    sd_dq_in = pat(0);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(req_ready == 1'b1, "R9", "ready in reset", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R9", "rd_valid in reset", int'(rd_valid), 0);
    chk(int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}) == 4'b0111, "R9", "cmd in reset",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 4'b0111);
    rst_n = 1'b1;
    cyc = 0; sd_dq_in = pat(0);
    repeat (4) tick();

    burst("R4", 1, 5,     1'b0, 3, 1'b0, 1'b1, -1, 1'b0, 1'b0); // BL8 wrap in block
    burst("R5", 2, 9'h1F6, 1'b0, 2, 1'b1, 1'b0, -1, 1'b0, 1'b0); // BL4 interleaved
    burst("R3", 3, 9'h123, 1'b1, 0, 1'b0, 1'b0, -1, 1'b0, 1'b0); // BL1 with precharge
    burst("R4", 0, 9'h1FF, 1'b0, 1, 1'b0, 1'b1, -1, 1'b0, 1'b0); // BL2 at top column
    burst("R5", 1, 9'h03A, 1'b1, 3, 1'b1, 1'b1, -1, 1'b0, 1'b0); // BL8 interleaved
    burst("R6", 2, 9'h1FC, 1'b0, 7, 1'b1, 1'b1, 10, 1'b0, 1'b0); // full page wraps
    burst("R6", 0, 9'h010, 1'b0, 7, 1'b0, 1'b0, 600, 1'b0, 1'b0); // full page > 512
    burst("R7", 3, 9'h044, 1'b0, 3, 1'b0, 1'b0, 2, 1'b0, 1'b0); // stop mid burst
    burst("R7", 1, 9'h0F0, 1'b0, 3, 1'b1, 1'b1, 0, 1'b0, 1'b0); // stop in read cycle
    burst("R3", 2, 9'h0C3, 1'b0, 5, 1'b1, 1'b0, -1, 1'b0, 1'b0); // reserved code
    burst("R2", 0, 9'h077, 1'b0, 2, 1'b0, 1'b1, -1, 1'b1, 1'b0); // busy request ignored
    burst("R10", 1, 9'h13D, 1'b0, 2, 1'b0, 1'b0, -1, 1'b0, 1'b1); // cfg wiggle
    // R7: stop while idle has no effect (command stays no-op)
    stop_req = 1'b1; tick(); stop_req = 1'b0;
    repeat (4) tick();
    burst("R4", 3, 9'h0E6, 1'b1, 2, 1'b0, 1'b1, -1, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule